// File: doc/BRIEF.md
# Serialized Interrupt Slave Agent

This block is the peripheral end of a single-wire, active-low serialized interrupt bus that runs on a shared clock. The host opens each bus cycle by holding the line low for several clocks. It then walks a fixed number of three-clock slots and closes the cycle with a stop pulse. The agent watches the line on every rising clock edge and recognises the opening low. It counts slots from the end of that low and reports the level of its local interrupt in the slot given by `slot_num`. The line is open-drain in style: the agent only drives it while `sirq_oe` is high, with the value on `sirq_out`. When `sirq_oe` is low the line is released and a pull-up holds it high.

The agent measures the width of the low pulse that closes every cycle, and that width sets the mode of the next cycle. In continuous mode the agent waits for the host to open the next cycle. In quiet mode the agent may open a cycle itself: it pulls the line low for one clock when its interrupt level differs from the level it last reported, and the host stretches that low into a full opening frame. A stop pulse of an unexpected width puts the agent back into continuous mode.

Top module: `sirq_slave`

## Requirements
- R1: After reset the line is released (`sirq_oe` = 0) and the agent is in continuous mode, so a change on `irq_level` before the first stop pulse causes no drive.
- R2: A cycle opens only when the line is sampled low for at least START_MIN (4) consecutive clocks and then high. A shorter low is ignored and no slot is reported after it.
- R3: If clock H is the first high clock after an opening low, slot n (numbered from 0) occupies clocks H+1+3n (sample), H+2+3n (recovery) and H+3+3n (turnaround), for n = 0 to NUM_SLOTS-1 (17 slots by default).
- R4: In its own slot, with `irq_level` = 0 (deasserted), the agent drives 0 in the sample clock, drives 1 in the recovery clock and releases in the turnaround clock. With `irq_level` = 1 (asserted) it leaves the line released for all three clocks.
- R5: The agent drives only during its own slot. A `slot_num` (binary slot index) of NUM_SLOTS or more never matches, and the agent never drives in a cycle.
- R6: A closing low of exactly QUIET_W (2) clocks makes the next cycle quiet.
- R7: A closing low of exactly CONT_W (3) clocks makes the next cycle continuous, and in that mode the agent never pulls the line low outside its slot.
- R8: A closing low of any other width (1 clock, or 4 clocks or more) is an error and selects continuous mode.
- R9: In quiet mode, while idle, with the line high and `irq_level` different from the last reported level, the agent drives 0 for exactly one clock and then releases. The earliest such clock is R+2, where R is the first high clock after the closing low.
- R10: In quiet mode, while `irq_level` equals the last reported level, the agent makes no request.
- R11: A request is never issued in the clock that detects the end of an opening low, and never during slots.
- R12: After its own request the agent treats the low stretched by the host as an opening frame and reports in its slot as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sirq_in | input | 1 | Sampled level of the shared line |
| irq_level | input | 1 | Local interrupt level, 1 = asserted |
| slot_num | input | SLOT_W (5) | Assigned slot index |
| sirq_oe | output | 1 | Line drive enable; 0 releases the line |
| sirq_out | output | 1 | Value driven while `sirq_oe` is 1 |

## Verification
In quiet mode, two events can land on the same rising edge. The edge that sees the end of an opening low can also meet every condition for a self-request: the agent is idle, the line is high and the interrupt level is unreported. This is unavoidable when the agent's own request started the frame, because its level is still unreported at that point. The bench provokes the collision by letting the agent request, having the host stretch the low, and checking that the first slot clock carries no stray drive. It runs this with the agent assigned to slot 0 and to slot 5. A checker property also forbids a request during slots.

// File: rtl/sirq_slave_pkg.sv
`timescale 1ns/1ps
package sirq_slave_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_FRAMES = 2'd1,
    BUS_STOP   = 2'd2
  } bus_phase_e;

  typedef enum logic {
    CYC_CONT  = 1'b0,
    CYC_QUIET = 1'b1
  } cyc_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drive_t;

  localparam logic [1:0] SUB_SAMPLE  = 2'd0;
  localparam logic [1:0] SUB_RECOVER = 2'd1;
  localparam logic [1:0] SUB_TURN    = 2'd2;

  // an opening low is long enough to start a cycle
  function automatic logic start_ok(input int unsigned width, input int unsigned min_w);
    return width >= min_w;
  endfunction

  // closing low width is neither of the two legal values
  function automatic logic stop_bad(input int unsigned width, input int unsigned quiet_w,
                                    input int unsigned cont_w);
    return (width != quiet_w) && (width != cont_w);
  endfunction

  // mode chosen by a closing low; anything not quiet falls back to continuous
  function automatic cyc_mode_e stop_mode(input int unsigned width, input int unsigned quiet_w);
    return (width == quiet_w) ? CYC_QUIET : CYC_CONT;
  endfunction

  // pin drive for one slot clock
  function automatic pin_drive_t slot_drive(input logic mine, input logic [1:0] sub,
                                            input logic irq, input logic low_sent);
    pin_drive_t d;
    d.oe  = 1'b0;
    d.val = 1'b1;
    if (mine) begin
      case (sub)
        SUB_SAMPLE:  begin d.oe = ~irq;     d.val = 1'b0; end
        SUB_RECOVER: begin d.oe = low_sent; d.val = 1'b1; end
        default:     begin d.oe = 1'b0;     d.val = 1'b1; end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/sirq_low_run.sv
`timescale 1ns/1ps
module sirq_low_run #(
  parameter int unsigned RUN_MAX = 5,
  localparam int unsigned RUN_W = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic [RUN_W-1:0] run_len,
  output logic             run_end
);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= '0;
    else if (line_in)                  run_q <= '0;
    else if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + 1'b1;
  end

  assign run_len = run_q;
  // a low run of run_q clocks ends at this edge
  assign run_end = line_in && (run_q != '0);

endmodule

// File: rtl/sirq_stop_decode.sv
`timescale 1ns/1ps
module sirq_stop_decode
  import sirq_slave_pkg::*;
#(
  parameter int unsigned QUIET_W = 2,
  parameter int unsigned CONT_W  = 3,
  parameter int unsigned RUN_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_end,
  input  logic [RUN_W-1:0] run_len,
  output cyc_mode_e        mode_q,
  output logic             stop_err
);

  logic bad_w;

  assign bad_w    = stop_bad(32'(run_len), QUIET_W, CONT_W);
  assign stop_err = stop_end && bad_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= CYC_CONT;
    else if (stop_end) mode_q <= bad_w ? CYC_CONT : stop_mode(32'(run_len), QUIET_W);
  end

endmodule

// File: rtl/sirq_slot_drive.sv
`timescale 1ns/1ps
module sirq_slot_drive
  import sirq_slave_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 17,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic              in_frames,
  input  logic              irq_level,
  input  logic [SLOT_W-1:0] slot_num,
  output logic              drv_oe,
  output logic              drv_val,
  output logic              frames_last,
  output logic              slot_hit,
  output logic              reported
);

  logic [SLOT_W-1:0] slot_q, nslot;
  logic [1:0]        sub_q, nsub;
  logic              nxt_valid, mine;
  logic              low_sent_q, rep_q;
  pin_drive_t        drive_q, nxt_drive;

  assign frames_last = in_frames && (slot_q == SLOT_W'(NUM_SLOTS - 1)) && (sub_q == SUB_TURN);
  assign nxt_valid   = frame_go || (in_frames && !frames_last);

  always_comb begin
    if (frame_go) begin
      nslot = '0;
      nsub  = SUB_SAMPLE;
    end else if (sub_q == SUB_TURN) begin
      nslot = slot_q + 1'b1;
      nsub  = SUB_SAMPLE;
    end else begin
      nslot = slot_q;
      nsub  = sub_q + 2'd1;
    end
  end

  assign mine      = nxt_valid && (nslot == slot_num);
  assign nxt_drive = slot_drive(mine, nsub, irq_level, low_sent_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      sub_q      <= SUB_SAMPLE;
      drive_q    <= '{oe: 1'b0, val: 1'b1};
      low_sent_q <= 1'b0;
      rep_q      <= 1'b0;
    end else begin
      drive_q <= nxt_drive;
      if (nxt_valid) begin
        slot_q <= nslot;
        sub_q  <= nsub;
      end
      if (mine && nsub == SUB_SAMPLE) begin
        rep_q      <= irq_level;
        low_sent_q <= ~irq_level;
      end
    end
  end

  assign drv_oe   = drive_q.oe;
  assign drv_val  = drive_q.val;
  assign slot_hit = in_frames && (slot_q == slot_num);
  assign reported = rep_q;

endmodule

// File: rtl/sirq_slave.sv
`timescale 1ns/1ps
module sirq_slave
  import sirq_slave_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 17,
  parameter int unsigned START_MIN = 4,
  parameter int unsigned QUIET_W   = 2,
  parameter int unsigned CONT_W    = 3,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sirq_in,
  input  logic              irq_level,
  input  logic [SLOT_W-1:0] slot_num,
  output logic              sirq_oe,
  output logic              sirq_out
);

  localparam int unsigned RUN_MAX = ((START_MIN > CONT_W) ? START_MIN : CONT_W) + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  bus_phase_e       phase_q, phase_d;
  cyc_mode_e        mode_q;
  logic [RUN_W-1:0] run_len;
  logic             run_end;
  logic             start_evt, stop_end, stop_err;
  logic             in_frames, frames_last, slot_hit;
  logic             drv_oe, drv_val, reported;
  logic             mode_quiet, req_want, req_oe;

  sirq_low_run #(.RUN_MAX(RUN_MAX)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (sirq_in),
    .run_len (run_len),
    .run_end (run_end)
  );

  assign start_evt = (phase_q == BUS_IDLE) && run_end && start_ok(32'(run_len), START_MIN);
  assign stop_end  = (phase_q == BUS_STOP) && run_end;
  assign in_frames = (phase_q == BUS_FRAMES);

  sirq_stop_decode #(.QUIET_W(QUIET_W), .CONT_W(CONT_W), .RUN_W(RUN_W)) u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_end (stop_end),
    .run_len  (run_len),
    .mode_q   (mode_q),
    .stop_err (stop_err)
  );

  sirq_slot_drive #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_go    (start_evt),
    .in_frames   (in_frames),
    .irq_level   (irq_level),
    .slot_num    (slot_num),
    .drv_oe      (drv_oe),
    .drv_val     (drv_val),
    .frames_last (frames_last),
    .slot_hit    (slot_hit),
    .reported    (reported)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      BUS_IDLE:   if (start_evt)   phase_d = BUS_FRAMES;
      BUS_FRAMES: if (frames_last) phase_d = BUS_STOP;
      BUS_STOP:   if (stop_end)    phase_d = BUS_IDLE;
      default:                     phase_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= BUS_IDLE;
    else        phase_q <= phase_d;
  end

  // self-request: quiet, idle, line high, level not yet reported
  assign mode_quiet = (mode_q == CYC_QUIET);
  assign req_want   = (phase_q == BUS_IDLE) && mode_quiet && sirq_in && (irq_level != reported);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_oe <= 1'b0;
    else        req_oe <= req_want && !start_evt;
  end

  assign sirq_oe  = req_oe | drv_oe;
  assign sirq_out = drv_oe & drv_val;

endmodule

// File: rtl/sirq_slave_chk.sv
`timescale 1ns/1ps
module sirq_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sirq_oe,
  input logic req_oe,
  input logic drv_oe,
  input logic drv_val,
  input logic slot_hit,
  input logic in_frames,
  input logic mode_quiet,
  input logic stop_err
);

  p_release_at_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sirq_oe);

  p_recovery_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe && !drv_val) |=> (drv_oe && drv_val));

  p_own_slot_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> slot_hit);

  p_req_quiet_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_oe |-> mode_quiet);

  p_err_to_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_err |=> !mode_quiet);

  p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_oe |=> !req_oe);

  p_no_req_in_frames_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_frames |-> !req_oe);

endmodule

bind sirq_slave sirq_slave_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sirq_oe    (sirq_oe),
  .req_oe     (req_oe),
  .drv_oe     (drv_oe),
  .drv_val    (drv_val),
  .slot_hit   (slot_hit),
  .in_frames  (in_frames),
  .mode_quiet (mode_quiet),
  .stop_err   (stop_err)
);

// File: tb/sirq_slave_tb_top.sv
`timescale 1ns/1ps
module sirq_slave_tb_top;

  localparam int N  = 17;
  localparam int SW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_level = 1'b0;
  logic [SW-1:0] slot_num = SW'(5);
  logic          host_lo = 1'b0;
  logic          sirq_in, sirq_oe, sirq_out;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  assign sirq_in = (sirq_oe ? sirq_out : 1'b1) & ~host_lo;

  sirq_slave #(.NUM_SLOTS(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sirq_in   (sirq_in),
    .irq_level (irq_level),
    .slot_num  (slot_num),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out)
  );

  task automatic chk(input string req, input logic exp_oe, input logic exp_val);
    n_checks++;
    if (sirq_oe !== exp_oe || (exp_oe && sirq_out !== exp_val)) begin
      n_errors++;
      $display("FAIL %s: oe=%b out=%b expected oe=%b out=%b", req, sirq_oe, sirq_out, exp_oe, exp_val);
    end
  endtask

  task automatic host_start(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      host_lo = 1'b1;
    end
    @(negedge clk);
    host_lo = 1'b0;
  endtask

  task automatic host_stop(input int width);
    for (int i = 0; i < width; i++) begin
      @(negedge clk);
      host_lo = 1'b1;
    end
    @(negedge clk);
    host_lo = 1'b0;
  endtask

  // R3 R4 R5: slot n sample at observation 3n+1, recovery 3n+2, turnaround 3n+3
  task automatic check_frames(input string req);
    for (int j = 1; j <= 3 * N; j++) begin
      int  s = (j - 1) / 3;
      int  p = (j - 1) % 3;
      bit  mine = (int'(slot_num) < N) && (s == int'(slot_num));
      bit  e_oe = mine && !irq_level && (p < 2);
      @(negedge clk);
      chk(req, e_oe, (p == 0) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic watch_none(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, 1'b0, 1'b0);
    end
  endtask

  // R9 R12: one-clock request, then the host stretches it into an opening frame
  task automatic req_tail(input string req);
    @(negedge clk);
    chk(req, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 single clock", 1'b0, 1'b0);
    host_lo = 1'b1;
    host_start(3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset release", 1'b0, 1'b0);
    irq_level = 1'b1;
    watch_none(8, "R1 continuous after reset");
    irq_level = 1'b0;
  endtask

  task automatic t_first_cycle_quiet_request;
    host_start(4);
    check_frames("R4 deasserted report");
    irq_level = 1'b1;
    host_stop(2);
    @(negedge clk);
    chk("R9 not before R+2", 1'b0, 1'b0);
    req_tail("R6 quiet request");
    check_frames("R11 R12 asserted report after request");
    host_stop(2);
    watch_none(6, "R10 no request when reported");
  endtask

  task automatic t_idle_change_then_cont;
    @(negedge clk);
    irq_level = 1'b0;
    chk("R10 before change seen", 1'b0, 1'b0);
    req_tail("R9 request on change");
    check_frames("R3 slot timing");
    host_stop(3);
    irq_level = 1'b1;
    watch_none(10, "R7 continuous no request");
    host_start(6);
    check_frames("R4 asserted released");
  endtask

  task automatic t_bad_stops_and_short_start;
    host_stop(1);
    irq_level = 1'b0;
    watch_none(10, "R8 short stop continuous");
    host_start(3);
    watch_none(3 * N, "R2 short start ignored");
    host_start(4);
    check_frames("R3 after short start");
    host_stop(5);
    irq_level = 1'b1;
    watch_none(10, "R8 long stop continuous");
  endtask

  task automatic t_slot_range_and_collision;
    slot_num = SW'(20);
    host_start(4);
    check_frames("R5 out of range slot");
    slot_num = SW'(0);
    host_stop(2);
    @(negedge clk);
    chk("R9 not before R+2", 1'b0, 1'b0);
    req_tail("R9 request slot0");
    check_frames("R11 collision slot0");
    host_stop(3);
    watch_none(4, "R7 idle after");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_cycle_quiet_request();
    t_idle_change_then_cont();
    t_bad_stops_and_short_start();
    t_slot_range_and_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule